// File: doc/BRIEF.md
# Five-Stage Pipelined 32-bit Integer Core

This block is a 32-bit in-order processor core with five stages: fetch, decode with register read, execute, data access and write-back. Each stage hands its work to the next through a pipeline register. It runs a small load/store instruction subset: four register-to-register ALU operations, word load, word store and branch-if-equal. It holds its own instruction memory and data memory, and it has a dedicated PC incrementer, so a fetch, a data access, a PC increment and an ALU operation can all take place in one cycle.

The core has no forwarding and no interlock. A result reaches a later instruction only through the register file. That file writes early in the cycle and reads late in the cycle, which is modelled as a write-through bypass. Software must therefore place at least two unrelated instructions (or NOPs) between a producer and its first consumer. A taken branch is resolved in execute, and the two younger instructions are turned into bubbles.

Both memories are filled through a load port while reset is held. A registered debug port reads any architectural register. A retire strobe with the retiring PC marks every instruction that reaches write-back.

Top module: `pipe5_core`

## Requirements
- R1: With cycle 1 as the first cycle in which `rst` is low, the instruction fetched from PC 0 retires in cycle 5. Every instruction that follows in sequence retires one cycle after the one before it. N sequential instructions therefore finish in cycle N+4. Retiring means `ret_valid` is high and `ret_pc` holds that instruction's address for one cycle.
- R2: While `rst` is high:
  - the PC becomes 0;
  - every pipeline register becomes a bubble, so `ret_valid` stays low;
  - all registers clear to zero;
  - `ld_we` writes `ld_data` to instruction-memory word `ld_addr` when `ld_sel`=0, or to data-memory word `ld_addr` when `ld_sel`=1.
- R3: The ALU instructions use opcode 0 (bits [31:26]), source registers in [25:21] and [20:16], destination in [15:11], and the function field in [5:0]. The function codes are 0x20 add, 0x22 subtract (first minus second), 0x24 AND and 0x25 OR.
- R4: Load (opcode 0x23) and store (opcode 0x2B) form the address as register [25:21] plus the sign-extended [15:0]. They access data-memory word address[..:2]. A load writes register [20:16]; a store writes that register's value to memory.
- R5: Branch-if-equal (opcode 0x04) compares registers [25:21] and [20:16]. When they are equal, the next fetch is PC+4+(sign-extended [15:0] << 2). The two instructions fetched after the branch never retire and change no state, and the target is fetched two cycles later than the sequential slot. A backward offset is allowed.
- R6: A register written in write-back is read with its new value by an instruction in decode in the same cycle. A consumer placed two instructions after its producer therefore sees the result.
- R7: Register 0 always reads as zero, both as an operand and on the debug port. Writes to it are dropped.
- R8: Any other opcode, or opcode 0 with another function code (including the all-zero NOP), changes no register or memory but still retires.
- R9: `dbg_rd` shows register `dbg_ra` as sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; the load port works only while it is high |
| ld_we | input | 1 | Load port write strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| dbg_ra | input | 5 | Register selected for debug read |
| dbg_rd | output | 32 | Registered value of the selected register |
| ret_valid | output | 1 | An instruction is in write-back this cycle |
| ret_pc | output | 32 | Address of that instruction |

## Verification
The hardest conditions to reach from the ports are the collision of a write-back with a decode read of the same register in the same cycle, and the squash of two younger instructions whose own effects would have been visible. The stimulus reaches the first with a hand-placed program: the second of two consecutive loads feeds an add exactly two slots later, so the add decodes in the very cycle the load writes back. For the second, the slots behind taken branches are filled with register-writing instructions. One forward branch lands on an address it has just squashed, and a final backward branch to itself keeps retiring every third cycle. A behavioural model predicts the retire cycle and PC on every clock, and literal expectations on the registers through the debug port confirm the architectural outcome.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  // Control word carried down the pipe; all-zero is a bubble
  typedef struct packed {
    logic    valid;
    logic    reg_dst;
    logic    alu_src;
    alu_op_e alu_op;
    logic    mem_rd;
    logic    mem_wr;
    logic    mem_to_reg;
    logic    reg_wr;
    logic    branch;
  } ctl_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] instr,
  output ctl_t        ctl
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctl = '0;
    ctl.valid = valid;
    if (valid) begin
      unique case (opc)
        OP_RTYPE: begin
          ctl.reg_dst = 1'b1;
          ctl.reg_wr  = 1'b1;
          unique case (fn)
            FN_ADD:  ctl.alu_op = ALU_ADD;
            FN_SUB:  ctl.alu_op = ALU_SUB;
            FN_AND:  ctl.alu_op = ALU_AND;
            FN_OR:   ctl.alu_op = ALU_OR;
            default: ctl.reg_wr = 1'b0;
          endcase
        end
        OP_LOAD: begin
          ctl.alu_src    = 1'b1;
          ctl.mem_rd     = 1'b1;
          ctl.mem_to_reg = 1'b1;
          ctl.reg_wr     = 1'b1;
        end
        OP_STORE: begin
          ctl.alu_src = 1'b1;
          ctl.mem_wr  = 1'b1;
        end
        OP_BEQ: begin
          ctl.alu_op = ALU_SUB;
          ctl.branch = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  ra1,
  input  logic [RAW-1:0]  ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RAW-1:0]  wa,
  input  logic [XLEN-1:0] wd,
  input  logic [RAW-1:0]  dbg_ra,
  output logic [XLEN-1:0] dbg_rd
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  always_ff @(posedge clk) dbg_rd <= regs[dbg_ra];

  // Early write / late read: a same-cycle write is seen by the reader
  function automatic logic [XLEN-1:0] rd_port(input logic [RAW-1:0] ra);
    if (ra == '0)              return '0;
    else if (we && wa == ra)   return wd;
    else                       return regs[ra];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic            ld_sel,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [RAW-1:0]  dbg_ra,
  output logic [XLEN-1:0] dbg_rd,
  output logic            ret_valid,
  output logic [XLEN-1:0] ret_pc
);
  // ---------------- fetch ----------------
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] pc, pc_plus4, fetch_word;
  logic            ex_taken;
  logic [XLEN-1:0] ex_target;

  always_ff @(posedge clk)
    if (rst && ld_we && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;

  assign fetch_word = imem[pc[IAW+1:2]];
  assign pc_plus4   = pc + XLEN'(4);   // dedicated incrementer

  always_ff @(posedge clk) begin
    if (rst)           pc <= '0;
    else if (ex_taken) pc <= ex_target;
    else               pc <= pc_plus4;
  end

  logic            ifid_v;
  logic [XLEN-1:0] ifid_pc4, ifid_pc, ifid_ir;

  always_ff @(posedge clk) begin
    if (rst || ex_taken) begin
      ifid_v <= 1'b0;
      ifid_ir <= '0;
    end else begin
      ifid_v <= 1'b1;
      ifid_ir <= fetch_word;
    end
    ifid_pc  <= pc;
    ifid_pc4 <= pc_plus4;
  end

  // ---------------- decode ----------------
  ctl_t            id_ctl;
  logic [XLEN-1:0] id_a, id_b, id_imm;
  logic            wb_we;
  logic [RAW-1:0]  wb_wa;
  logic [XLEN-1:0] wb_wd;

  pipe5_decode u_dec (
    .valid (ifid_v),
    .instr (ifid_ir),
    .ctl   (id_ctl)
  );

  pipe5_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ra1    (ifid_ir[21 +: RAW]),
    .ra2    (ifid_ir[16 +: RAW]),
    .rd1    (id_a),
    .rd2    (id_b),
    .we     (wb_we),
    .wa     (wb_wa),
    .wd     (wb_wd),
    .dbg_ra (dbg_ra),
    .dbg_rd (dbg_rd)
  );

  assign id_imm = {{(XLEN-16){ifid_ir[15]}}, ifid_ir[15:0]};

  ctl_t            idex_ctl;
  logic [XLEN-1:0] idex_pc, idex_pc4, idex_a, idex_b, idex_imm;
  logic [RAW-1:0]  idex_rt, idex_rd;

  always_ff @(posedge clk) begin
    if (rst || ex_taken) idex_ctl <= '0;
    else                 idex_ctl <= id_ctl;
    idex_pc  <= ifid_pc;
    idex_pc4 <= ifid_pc4;
    idex_a   <= id_a;
    idex_b   <= id_b;
    idex_imm <= id_imm;
    idex_rt  <= ifid_ir[16 +: RAW];
    idex_rd  <= ifid_ir[11 +: RAW];
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_y;
  logic            ex_zero;

  pipe5_alu #(.XLEN(XLEN)) u_alu (
    .a    (idex_a),
    .b    (idex_ctl.alu_src ? idex_imm : idex_b),
    .op   (idex_ctl.alu_op),
    .y    (ex_y),
    .zero (ex_zero)
  );

  assign ex_target = idex_pc4 + {idex_imm[XLEN-3:0], 2'b00};
  assign ex_taken  = idex_ctl.branch && ex_zero;

  ctl_t            exmem_ctl;
  logic [XLEN-1:0] exmem_pc, exmem_y, exmem_sd;
  logic [RAW-1:0]  exmem_wa;

  always_ff @(posedge clk) begin
    if (rst) exmem_ctl <= '0;
    else     exmem_ctl <= idex_ctl;
    exmem_pc <= idex_pc;
    exmem_y  <= ex_y;
    exmem_sd <= idex_b;
    exmem_wa <= idex_ctl.reg_dst ? idex_rd : idex_rt;
  end

  // ---------------- memory ----------------
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_we && ld_sel) dmem[ld_addr[DAW-1:0]] <= ld_data;
    end else if (exmem_ctl.mem_wr) begin
      dmem[exmem_y[DAW+1:2]] <= exmem_sd;
    end
  end

  assign mem_rdata = dmem[exmem_y[DAW+1:2]];

  ctl_t            memwb_ctl;
  logic [XLEN-1:0] memwb_pc, memwb_wd;
  logic [RAW-1:0]  memwb_wa;

  always_ff @(posedge clk) begin
    if (rst) memwb_ctl <= '0;
    else     memwb_ctl <= exmem_ctl;
    memwb_pc <= exmem_pc;
    memwb_wd <= (exmem_ctl.mem_rd && exmem_ctl.mem_to_reg) ? mem_rdata : exmem_y;
    memwb_wa <= exmem_wa;
  end

  // ---------------- write-back ----------------
  assign wb_we     = memwb_ctl.reg_wr;
  assign wb_wa     = memwb_wa;
  assign wb_wd     = memwb_wd;
  assign ret_valid = memwb_ctl.valid;
  assign ret_pc    = memwb_pc;

  // stage-valid taps for the checker
  logic idex_v, exmem_v;
  assign idex_v  = idex_ctl.valid;
  assign exmem_v = exmem_ctl.valid;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            ret_valid,
  input logic [XLEN-1:0] ret_pc,
  input logic            ex_taken,
  input logic            ifid_v,
  input logic            idex_v,
  input logic            exmem_v,
  input logic [XLEN-1:0] exmem_pc,
  input logic [RAW-1:0]  dbg_ra,
  input logic [XLEN-1:0] dbg_rd
);
  AST_RESET_NO_RETIRE: assert property (@(posedge clk) rst |=> !ret_valid); // R2

  AST_SQUASH_YOUNGER: assert property (@(posedge clk) disable iff (rst)
    ex_taken |=> (!ifid_v && !idex_v)); // R5

  AST_MEM_TO_RETIRE: assert property (@(posedge clk) disable iff (rst)
    exmem_v |=> (ret_valid && ret_pc == $past(exmem_pc))); // R1

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
    $past(dbg_ra) == '0 |-> dbg_rd == '0); // R7

  AST_TAKEN_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
    ex_taken |-> idex_v); // R5
endmodule

bind pipe5_core pipe5_core_chk #(.XLEN(32), .RAW(5)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ret_valid (ret_valid),
  .ret_pc    (ret_pc),
  .ex_taken  (ex_taken),
  .ifid_v    (ifid_v),
  .idex_v    (idex_v),
  .exmem_v   (exmem_v),
  .exmem_pc  (exmem_pc),
  .dbg_ra    (dbg_ra),
  .dbg_rd    (dbg_rd)
);

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_sel = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_ra = '0;
  logic [31:0] dbg_rd;
  logic        ret_valid;
  logic [31:0] ret_pc;

  always #2.5 clk = ~clk;

  pipe5_core i_pipe5_core (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_ra(dbg_ra), .dbg_rd(dbg_rd),
    .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  int n_cmp = 0, n_bad = 0, edges = 0;
  bit [31:0] prog [64];
  bit [31:0] dinit [64];
  bit [31:0] mreg [32];
  bit [31:0] mdm [64];
  int        q_cyc [$];
  bit [31:0] q_pc [$];
  bit [31:0] mpc;
  int        nf;
  string     seq_tag;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [31:0] rty(int fn, int s, int t, int d);
    bit [31:0] w = {6'd0, s[4:0], t[4:0], d[4:0], 5'd0, fn[5:0]};
    return w;
  endfunction

  function automatic bit [31:0] ity(int op, int s, int t, int imm);
    bit [31:0] w = {op[5:0], s[4:0], t[4:0], imm[15:0]};
    return w;
  endfunction

  // behavioural reference: executes at fetch time, predicts retire slot
  task automatic model_fetch();
    bit [31:0] ins = prog[(mpc >> 2) % 64];
    int s = ins[25:21], t = ins[20:16], d = ins[15:11];
    bit [31:0] imm = {{16{ins[15]}}, ins[15:0]};
    bit [31:0] nxt = mpc + 4;
    int step = 1;
    bit [31:0] ea = mreg[s] + imm;
    q_cyc.push_back(nf + 3);
    q_pc.push_back(mpc);
    case (ins[31:26])
      6'h00: begin
        bit [31:0] r; bit wr = 1;
        case (ins[5:0])
          6'h20: r = mreg[s] + mreg[t];
          6'h22: r = mreg[s] - mreg[t];
          6'h24: r = mreg[s] & mreg[t];
          6'h25: r = mreg[s] | mreg[t];
          default: wr = 0;
        endcase
        if (wr && d != 0) mreg[d] = r;
      end
      6'h23: if (t != 0) mreg[t] = mdm[(ea >> 2) % 64];
      6'h2B: mdm[(ea >> 2) % 64] = mreg[t];
      6'h04: if (mreg[s] == mreg[t]) begin nxt = mpc + 4 + (imm << 2); step = 3; end
      default: ;
    endcase
    mpc = nxt;
    nf += step;
  endtask

  task automatic load_and_reset();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      ld_we = 1; ld_sel = 0; ld_addr = 6'(i); ld_data = prog[i];
      @(negedge clk);
      ld_sel = 1; ld_data = dinit[i];
      @(negedge clk);
    end
    ld_we = 0;
    dbg_ra = 5'd4;
    @(negedge clk);
    check(ret_valid == 1'b0, "R2", "retire during reset", ret_valid, 0);
    check(dbg_rd == 32'd0, "R2", "register 4 cleared by reset", dbg_rd, 0);
    for (int r = 0; r < 32; r++) mreg[r] = 0;
    for (int i = 0; i < 64; i++) mdm[i] = dinit[i];
    mpc = 0; nf = 1; edges = 0;
    q_cyc.delete(); q_pc.delete();
    rst = 1'b0;
  endtask

  task automatic run_cycles(input int n, input int last_pc, input int last_edge);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (edges == nf) model_fetch();
      begin
        bit ev = (q_cyc.size() > 0) && (q_cyc[0] == edges);
        check(ret_valid == ev, seq_tag, "retire strobe", ret_valid, ev);
        if (ev) begin
          check(ret_pc == q_pc[0], seq_tag, "retire pc", ret_pc, q_pc[0]);
          void'(q_cyc.pop_front());
          void'(q_pc.pop_front());
        end
        if (ret_valid && ret_pc == 32'(last_pc) && last_edge > 0)
          check(edges == last_edge, "R1", "N-th instruction write-back cycle", edges, last_edge);
      end
    end
  endtask

  task automatic read_reg(input int r, input bit [31:0] exp, input string req);
    dbg_ra = 5'(r);
    @(posedge clk); edges++;
    @(negedge clk);
    if (edges == nf) model_fetch();
    if (q_cyc.size() > 0 && q_cyc[0] == edges) begin
      void'(q_cyc.pop_front()); void'(q_pc.pop_front());
    end
    check(dbg_rd == exp, req, $sformatf("register %0d", r), dbg_rd, exp);
  endtask

  initial begin
    // ---- sequence 1: ALU ops, loads/stores, bypass, zero register, unknown op
    for (int i = 0; i < 64; i++) begin prog[i] = 0; dinit[i] = 0; end
    dinit[0] = 32'd5; dinit[1] = 32'd12; dinit[2] = 32'h0F0F00FF;
    prog[0]  = ity(6'h23, 0, 1, 0);
    prog[1]  = ity(6'h23, 0, 2, 4);
    prog[2]  = ity(6'h23, 0, 3, 8);
    prog[4]  = rty(6'h20, 1, 2, 4);
    prog[5]  = rty(6'h22, 1, 2, 5);
    prog[6]  = rty(6'h24, 3, 2, 6);
    prog[7]  = rty(6'h25, 3, 1, 7);
    prog[8]  = rty(6'h20, 1, 2, 0);
    prog[9]  = ity(6'h2B, 0, 4, 12);
    prog[12] = ity(6'h23, 0, 8, 12);
    prog[13] = rty(6'h20, 0, 1, 9);
    prog[14] = ity(6'h08, 0, 10, 100);
    load_and_reset();
    seq_tag = "R1";
    run_cycles(3, -1, 0);
    check(ret_valid == 1'b0, "R1", "pipeline still filling", ret_valid, 0);
    run_cycles(50, 52, 17);
    read_reg(4, 32'd17, "R6");
    read_reg(5, 32'hFFFFFFF9, "R3");
    read_reg(6, 32'h0000000C, "R3");
    read_reg(7, 32'h0F0F00FF, "R3");
    read_reg(0, 32'd0, "R7");
    read_reg(8, 32'd17, "R4");
    read_reg(9, 32'd5, "R7");
    read_reg(10, 32'd0, "R8");
    read_reg(1, 32'd5, "R4");
    // debug port latency
    dbg_ra = 5'd2;
    #1;
    check(dbg_rd == 32'd5, "R9", "debug output before edge", dbg_rd, 5);
    @(posedge clk); edges++;
    @(negedge clk);
    if (edges == nf) model_fetch();
    if (q_cyc.size() > 0 && q_cyc[0] == edges) begin
      void'(q_cyc.pop_front()); void'(q_pc.pop_front());
    end
    check(dbg_rd == 32'd12, "R9", "debug output after edge", dbg_rd, 12);
    for (int r = 0; r < 32; r++) read_reg(r, mreg[r], "R9");

    // ---- sequence 2: taken/not-taken branches and squash
    for (int i = 0; i < 64; i++) begin prog[i] = 0; dinit[i] = 0; end
    dinit[0] = 32'd7; dinit[1] = 32'd7; dinit[2] = 32'd3;
    prog[0]  = ity(6'h23, 0, 1, 0);
    prog[1]  = ity(6'h23, 0, 2, 4);
    prog[2]  = ity(6'h23, 0, 3, 8);
    prog[5]  = ity(6'h04, 1, 2, 2);
    prog[6]  = rty(6'h20, 1, 1, 4);
    prog[7]  = rty(6'h20, 1, 1, 5);
    prog[8]  = rty(6'h20, 1, 3, 6);
    prog[9]  = ity(6'h04, 1, 3, 5);
    prog[10] = rty(6'h22, 1, 3, 7);
    prog[11] = ity(6'h04, 0, 0, 1);
    prog[12] = rty(6'h20, 1, 1, 8);
    prog[13] = rty(6'h25, 1, 3, 9);
    prog[14] = ity(6'h04, 0, 0, -1);
    load_and_reset();
    seq_tag = "R5";
    run_cycles(60, -1, 0);
    read_reg(4, 32'd0, "R5");
    read_reg(5, 32'd0, "R5");
    read_reg(6, 32'd10, "R5");
    read_reg(7, 32'd4, "R5");
    read_reg(8, 32'd0, "R5");
    read_reg(9, 32'd7, "R5");
    for (int r = 0; r < 32; r++) read_reg(r, mreg[r], "R9");
    seq_tag = "R5";
    run_cycles(12, -1, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule